// File: doc/BRIEF.md
# Receive Buffer Credit Flow Control

This block keeps, for each group of receive channels, a count of the free receive buffers that software has handed to the hardware. Software adds to the count by writing an allocation word. The DMA channel removes one unit each time it fills a buffer. The count is compared with two programmable thresholds, and the result drives a pause request back toward the packet source. The pause request turns on when free buffers run short. It turns off only once the count has climbed past the upper threshold, so it does not chatter near a single level.

A group's allocation register has a force bit. Writing the register with this bit set suspends throttling for that group until an ordinary allocation write arrives. Each group is switched on by its own bit in a shared configuration word. While a group is off, its count is held at zero and its pause request stays low. Register writes arrive on a simple write-only strobe, address and data bus. The DMA side supplies one buffer-used pulse per group.

Top module: `rx_credit_fc`

## Requirements
- R1: After a synchronous active-low reset, every group is disabled, every credit count is 0, every pause request is low and every threshold is 0.
- R2: Byte address 0 holds the group enables, with group g enabled by data bit g+1. For group g, the low threshold is at 4+12g, the high threshold at 8+12g and the allocation word at 12+12g. Only data bits [CRED_W-1:0] carry a value, plus bit 31 in the allocation word. Any other address is ignored.
- R3: An allocation write with bit 31 clear, to an enabled group, adds data[CRED_W-1:0] to that group's count on the same edge. The count saturates at 2^CRED_W-1.
- R4: A buffer-used pulse lowers the group's count by one on the next edge. At 0 the count stays 0, and the count never rises without an allocation write.
- R5: An allocation and a buffer-used pulse in the same cycle both take effect: new count = min(max(count+added-1, 0), 2^CRED_W-1).
- R6: The pause request is updated on the same edge as the count, using the new count and the thresholds held before that edge. It is set if new count < low threshold, cleared if new count > high threshold, and held otherwise.
- R7: An allocation write with bit 31 set leaves the count unchanged. It holds the pause request low from that edge until an allocation write with bit 31 clear.
- R8: While a group is disabled, its count is driven to 0 at every edge, its pause request is low, and allocation writes add nothing.
- R9: Writes and buffer-used pulses for one group never change another group's count or pause request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| buf_used | input | NUM_GRP | Per-group one-cycle pulse: one receive buffer filled |
| pause_req | output | NUM_GRP | Per-group pause request toward the packet source |
| credit_cnt | output | NUM_GRP*CRED_W | Per-group free-buffer count, group g in bits [g*CRED_W +: CRED_W] |

## Verification
A wrong credit value shows on credit_cnt at the edge after the offending write or pulse, because the count is a register wired straight to the port. A fault in the hysteresis state is different. It shows only while the count sits between the two thresholds, where the pause request must keep its old value. The sweeps therefore walk the count up and down through that band for many threshold pairs. Saturation, force and disable faults show up on both outputs within one cycle of the triggering stimulus.

// File: rtl/rxfc_pkg.sv
// Shared constants for the receive credit flow-control block.
// Assumes byte addressing with 32-bit registers.
package rxfc_pkg;
    localparam int unsigned CFG_ADDR   = 0;   // group enable word
    localparam int unsigned GRP_STRIDE = 12;  // bytes between groups
    localparam int unsigned LO_OFS     = 4;
    localparam int unsigned HI_OFS     = 8;
    localparam int unsigned ALLOC_OFS  = 12;
    localparam int unsigned FORCE_BIT  = 31;
endpackage

// File: rtl/rxfc_regdec.sv
// Register decoder: holds group enables and thresholds, and produces
// per-group allocation strobes with the decoded add value and force bit.
// Assumes NUM_GRP <= 30 so enable bits fit below the force bit.
module rxfc_regdec #(
    parameter int unsigned NUM_GRP = 4,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CRED_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    output logic [NUM_GRP-1:0]          grp_en,
    output logic [NUM_GRP*CRED_W-1:0]   lo_flat,
    output logic [NUM_GRP*CRED_W-1:0]   hi_flat,
    output logic [NUM_GRP-1:0]          alloc_we,
    output logic [CRED_W-1:0]           add_val,
    output logic                        force_bit
);
    import rxfc_pkg::*;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    assign add_val   = wdata[CRED_W-1:0];
    assign force_bit = wdata[FORCE_BIT];

    // Enable word: group g follows data bit g+1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp_en <= '0;
        else if (we && addr == ADDR_W'(CFG_ADDR))
            grp_en <= wdata[NUM_GRP:1];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int unsigned BASE = g * GRP_STRIDE;

        // Allocation strobe for this group.
        assign alloc_we[g] = we && (addr == ADDR_W'(BASE + ALLOC_OFS));

        // Threshold storage for this group.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_flat[g*CRED_W +: CRED_W] <= '0;
                hi_flat[g*CRED_W +: CRED_W] <= '0;
            end else if (we) begin
                if (addr == ADDR_W'(BASE + LO_OFS))
                    lo_flat[g*CRED_W +: CRED_W] <= wdata[CRED_W-1:0];
                if (addr == ADDR_W'(BASE + HI_OFS))
                    hi_flat[g*CRED_W +: CRED_W] <= wdata[CRED_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rxfc_credit.sv
// Credit counter for one group: saturating add of allocated buffers,
// saturating decrement per used buffer, plus the force flag.
// Assumes add and use in one cycle are combined before clamping.
module rxfc_credit #(
    parameter int unsigned CRED_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              alloc_we,
    input  logic [CRED_W-1:0] add_val,
    input  logic              force_bit,
    input  logic              used,
    output logic [CRED_W-1:0] cnt_q,
    output logic [CRED_W-1:0] cnt_nxt,
    output logic              force_q,
    output logic              force_nxt
);
    localparam int unsigned SUM_W = CRED_W + 1;
    localparam logic [SUM_W-1:0] CAP = {1'b0, {CRED_W{1'b1}}};

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] net;

    // Next count: add credits, remove one per used buffer, clamp both ends.
    always_comb begin
        sum = {1'b0, cnt_q};
        if (alloc_we && !force_bit)
            sum = sum + {1'b0, add_val};
        net = sum;
        if (used && sum != '0)
            net = sum - 1'b1;
        if (net > CAP)
            net = CAP;
        cnt_nxt   = en ? net[CRED_W-1:0] : '0;
        force_nxt = alloc_we ? force_bit : force_q;
    end

    // Count and force flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            force_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_nxt;
            force_q <= force_nxt;
        end
    end
endmodule

// File: rtl/rxfc_hyst.sv
// Pause generator for one group: sets below the low threshold, clears
// above the high threshold, holds in between; low when off or forced.
// Assumes the low-threshold test wins if thresholds are inverted.
module rxfc_hyst #(
    parameter int unsigned CRED_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              force_nxt,
    input  logic [CRED_W-1:0] cnt_nxt,
    input  logic [CRED_W-1:0] lo,
    input  logic [CRED_W-1:0] hi,
    output logic              pause_q
);
    logic pause_nxt;

    // Hysteresis decision on the incoming count.
    always_comb begin
        if (!en || force_nxt)
            pause_nxt = 1'b0;
        else if (cnt_nxt < lo)
            pause_nxt = 1'b1;
        else if (cnt_nxt > hi)
            pause_nxt = 1'b0;
        else
            pause_nxt = pause_q;
    end

    // Pause register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pause_q <= 1'b0;
        else
            pause_q <= pause_nxt;
    end
endmodule

// File: rtl/rx_credit_fc.sv
// Receive buffer credit flow control, NUM_GRP independent groups.
// Assumes one buffer-used pulse per group per cycle at most.
module rx_credit_fc #(
    parameter int unsigned NUM_GRP = 4,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CRED_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [31:0]               cfg_wdata,
    input  logic [NUM_GRP-1:0]        buf_used,
    output logic [NUM_GRP-1:0]        pause_req,
    output logic [NUM_GRP*CRED_W-1:0] credit_cnt
);
    logic [NUM_GRP-1:0]        grp_en;
    logic [NUM_GRP*CRED_W-1:0] lo_flat;
    logic [NUM_GRP*CRED_W-1:0] hi_flat;
    logic [NUM_GRP-1:0]        alloc_we;
    logic [CRED_W-1:0]         add_val;
    logic                      force_bit;
    logic [NUM_GRP-1:0]        grp_force;
    logic [NUM_GRP-1:0]        grp_force_nxt;

    rxfc_regdec #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .CRED_W(CRED_W)) i_regdec (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .grp_en    (grp_en),
        .lo_flat   (lo_flat),
        .hi_flat   (hi_flat),
        .alloc_we  (alloc_we),
        .add_val   (add_val),
        .force_bit (force_bit)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [CRED_W-1:0] cnt_nxt;

        rxfc_credit #(.CRED_W(CRED_W)) i_credit (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (grp_en[g]),
            .alloc_we  (alloc_we[g]),
            .add_val   (add_val),
            .force_bit (force_bit),
            .used      (buf_used[g]),
            .cnt_q     (credit_cnt[g*CRED_W +: CRED_W]),
            .cnt_nxt   (cnt_nxt),
            .force_q   (grp_force[g]),
            .force_nxt (grp_force_nxt[g])
        );

        rxfc_hyst #(.CRED_W(CRED_W)) i_hyst (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (grp_en[g]),
            .force_nxt (grp_force_nxt[g]),
            .cnt_nxt   (cnt_nxt),
            .lo        (lo_flat[g*CRED_W +: CRED_W]),
            .hi        (hi_flat[g*CRED_W +: CRED_W]),
            .pause_q   (pause_req[g])
        );
    end
endmodule

// File: rtl/rxfc_chk.sv
// Property checker for rx_credit_fc, attached by bind.
module rxfc_chk #(
    parameter int unsigned NUM_GRP = 4,
    parameter int unsigned CRED_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_GRP-1:0]        grp_en,
    input logic [NUM_GRP-1:0]        alloc_we,
    input logic [NUM_GRP*CRED_W-1:0] lo_flat,
    input logic [NUM_GRP-1:0]        grp_force,
    input logic [NUM_GRP-1:0]        pause_req,
    input logic [NUM_GRP*CRED_W-1:0] credit_cnt
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        // R8
        off_pause_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_en[g] |=> !pause_req[g]);
        // R8
        off_credit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_en[g] |=> credit_cnt[g*CRED_W +: CRED_W] == '0);
        // R4
        no_free_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !alloc_we[g] |=> credit_cnt[g*CRED_W +: CRED_W] <= $past(credit_cnt[g*CRED_W +: CRED_W]));
        // R6
        pause_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pause_req[g]) |-> credit_cnt[g*CRED_W +: CRED_W] < $past(lo_flat[g*CRED_W +: CRED_W]));
        // R7
        forced_no_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_force[g] |-> !pause_req[g]);
    end
endmodule

bind rx_credit_fc rxfc_chk #(.NUM_GRP(NUM_GRP), .CRED_W(CRED_W)) i_rxfc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_en     (grp_en),
    .alloc_we   (alloc_we),
    .lo_flat    (lo_flat),
    .grp_force  (grp_force),
    .pause_req  (pause_req),
    .credit_cnt (credit_cnt)
);

// File: tb/test_rx_credit_fc.sv
`timescale 1ns/1ps
module test_rx_credit_fc;
    localparam int NG = 4;
    localparam int CW = 8;
    localparam int AW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n;
    logic               cfg_we;
    logic [AW-1:0]      cfg_addr;
    logic [31:0]        cfg_wdata;
    logic [NG-1:0]      buf_used;
    logic [NG-1:0]      pause_req;
    logic [NG*CW-1:0]   credit_cnt;

    rx_credit_fc #(.NUM_GRP(NG), .ADDR_W(AW), .CRED_W(CW)) i_rx_credit_fc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .buf_used(buf_used),
        .pause_req(pause_req), .credit_cnt(credit_cnt)
    );

    int errors = 0;
    int checks = 0;
    int m_cnt [NG];
    int m_lo  [NG];
    int m_hi  [NG];
    bit m_en  [NG];
    bit m_f   [NG];
    bit m_p   [NG];

    task automatic chk(string req, string what, int g, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s group %0d %s: actual=%0d expected=%0d", req, g, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int g = 0; g < NG; g++) begin
            chk(req, "credit", g, int'(credit_cnt[g*CW +: CW]), m_cnt[g]);
            chk(req, "pause", g, int'(pause_req[g]), int'(m_p[g]));
        end
    endtask

    // One cycle of stimulus, model update, and output check.
    task automatic step(bit we, int addr, logic [31:0] data, logic [NG-1:0] used, string req);
        int s;
        int ncnt;
        bit aw;
        bit nf;
        cfg_we    = we;
        cfg_addr  = AW'(addr);
        cfg_wdata = data;
        buf_used  = used;
        for (int g = 0; g < NG; g++) begin
            aw = we && (addr == 12 + 12 * g);
            s  = m_cnt[g];
            if (aw && !data[31]) s += int'(data[CW-1:0]);
            if (used[g] && s > 0) s--;
            if (s > CMAX) s = CMAX;
            ncnt = m_en[g] ? s : 0;
            nf   = aw ? data[31] : m_f[g];
            if (!m_en[g] || nf)      m_p[g] = 1'b0;
            else if (ncnt < m_lo[g]) m_p[g] = 1'b1;
            else if (ncnt > m_hi[g]) m_p[g] = 1'b0;
            m_cnt[g] = ncnt;
            m_f[g]   = nf;
            if (we && addr == 4 + 12 * g) m_lo[g] = int'(data[CW-1:0]);
            if (we && addr == 8 + 12 * g) m_hi[g] = int'(data[CW-1:0]);
        end
        if (we && addr == 0)
            for (int g = 0; g < NG; g++) m_en[g] = data[g+1];
        @(posedge clk);
        @(negedge clk);
        cfg_we   = 1'b0;
        buf_used = '0;
        check_all(req);
    endtask

    task automatic wr(int addr, logic [31:0] data, string req);
        step(1'b1, addr, data, '0, req);
    endtask

    task automatic use_buf(logic [NG-1:0] mask, string req);
        step(1'b0, 200, 32'h0, mask, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; buf_used = '0;
        for (int g = 0; g < NG; g++) begin
            m_cnt[g] = 0; m_lo[g] = 0; m_hi[g] = 0; m_en[g] = 0; m_f[g] = 0; m_p[g] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        // R1: thresholds reset to 0, so pause stays low after enabling
        wr(0, 32'h0000_000E, "R1");
        use_buf(4'b0001, "R1");

        // R2: thresholds for groups 0 and 2
        wr(4, 3, "R2");
        wr(8, 6, "R2");
        wr(28, 1, "R2");
        wr(32, 2, "R2");

        // R6: walk group 0 up through and past the band, then down
        for (int i = 0; i < 9; i++) wr(12, 1, "R6");
        for (int i = 0; i < 11; i++) use_buf(4'b0001, "R6");
        // R4: decrement saturates at zero
        use_buf(4'b0001, "R4");

        // R3: multi-credit add
        wr(12, 5, "R3");
        // R5: add and use together
        step(1'b1, 12, 32'd2, 4'b0001, "R5");
        // R3: saturation at the top
        wr(12, 250, "R3");
        wr(12, 10, "R3");
        // R5: add and use at the saturated top
        step(1'b1, 12, 32'd1, 4'b0001, "R5");
        for (int i = 0; i < 258; i++) use_buf(4'b0001, "R4");

        // R2: bits 30..CW ignored, and unmapped addresses ignored
        wr(12, 32'h7FFF_FF02, "R2");
        wr(64, 32'h0000_00FF, "R2");
        wr(2, 32'h0000_00FF, "R2");
        wr(1, 32'h0000_00FF, "R2");

        // R7: force holds pause low while draining below low threshold
        wr(12, 32'h8000_0000, "R7");
        for (int i = 0; i < 4; i++) use_buf(4'b0001, "R7");
        wr(12, 32'h8000_0007, "R7");
        wr(12, 32'h0000_0000, "R7");

        // R9: interleaved activity on groups 0 and 2
        wr(36, 4, "R9");
        step(1'b1, 36, 32'd1, 4'b0101, "R9");
        use_buf(4'b0111, "R9");
        for (int i = 0; i < 5; i++) use_buf(4'b0100, "R9");

        // R6: sweep threshold pairs on group 1
        for (int lo = 0; lo < 5; lo++) begin
            for (int hi = lo; hi < lo + 4; hi++) begin
                wr(16, lo, "R6");
                wr(20, hi, "R6");
                for (int i = 0; i < 9; i++) wr(24, 1, "R6");
                for (int i = 0; i < 10; i++) use_buf(4'b0010, "R6");
            end
        end

        // R8: disable groups 0 and 1; allocations and uses have no effect
        wr(0, 32'h0000_0008, "R8");
        wr(12, 9, "R8");
        use_buf(4'b0011, "R8");
        wr(48, 20, "R8");
        wr(24, 32'h0000_0003, "R8");
        // R8: re-enable group 0 and allocate
        wr(0, 32'h0000_000A, "R8");
        wr(12, 4, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule